// File: doc/BRIEF.md
# Dual-Master Wide ROM Arbiter

This block lets two byte-wide processor ports share one ROM that is 16 bits wide. The fast master runs on the base clock. The slow master runs at a quarter of that rate and may start an access only in a fixed slot that recurs every four base cycles. Every ROM access fetches a whole aligned word, which takes two base cycles. The block keeps the last word fetched for the fast master in a one-word buffer, so the fast master gets a following odd-byte read in a single cycle without a ROM access.

Each port has a level request, a 24-bit byte address, a device-select input that marks the access as aimed at this ROM, a one-cycle ready pulse, and the returned byte. A master holds its request and address until it sees ready. In the cycle after ready it must either drop the request or present its next address. When both masters want the ROM in the slot, the slow master wins and the fast master waits one cycle. Requests with device-select low belong to other devices. They are ignored and block nothing.

Top module: `wide_rom_arbiter`

## Requirements
- R1: After reset both ready outputs and `rom_en_o` are low, and the buffer is empty, so the first odd-byte read by the fast master starts a ROM cycle.
- R2: When no slow grant is pending, a fast request that misses the buffer is accepted at the next clock edge. `rom_en_o` is then high for one cycle with `rom_addr_o` = addr[23:1], and ready pulses after the following edge, two edges after the request was first seen. The byte is little-endian: addr[0]=0 returns `rom_data_i[7:0]` and addr[0]=1 returns `rom_data_i[15:8]`.
- R3: A fast request with addr[0]=1 whose addr[23:1] matches a valid buffered word gets ready after one edge, with the buffered upper byte and no ROM cycle.
- R4: A fast request with addr[0]=0 always starts a ROM cycle, even when its word is in the buffer.
- R5: The slot is the edge at which the phase counter reads 0. It is the first edge after reset and every fourth edge after that. A slow request is sampled only at a slot and gets ready two edges after that slot. A request raised just after a slot waits for the next one.
- R6: When the slow master and a fast miss both want the ROM at a slot, the slow word is fetched first and the fast miss is accepted one edge later, so its ready comes three edges after the request.
- R7: A request with its device-select low produces no ROM cycle and no ready. A slow request with device-select low does not delay a fast access.
- R8: A fast buffer hit is served in one edge even when it coincides with a slow grant.
- R9: A slow fetch of a word other than the buffered one empties the buffer, and a slow fetch of the same word leaves it valid. If a fast fill completes at the same edge as such a slow grant, the fill wins and the buffer stays valid.
- R10: A fast miss accepted at the edge just before a slot completes with normal latency while the slow master is granted at that slot.
- R11: Sequential fast reads that alternate even and odd bytes of the same word deliver two bytes every three cycles. Back-to-back misses deliver one byte every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_req_i | input | 1 | Fast master request, held until ready |
| fast_addr_i | input | 24 | Fast master byte address |
| fast_sel_i | input | 1 | Fast request targets this ROM |
| fast_ready_o | output | 1 | One-cycle pulse, fast byte valid |
| fast_rdata_o | output | 8 | Byte returned to the fast master |
| slow_req_i | input | 1 | Slow master request, sampled only at a slot |
| slow_addr_i | input | 24 | Slow master byte address |
| slow_sel_i | input | 1 | Slow request targets this ROM |
| slow_ready_o | output | 1 | One-cycle pulse, slow byte valid |
| slow_rdata_o | output | 8 | Byte returned to the slow master |
| rom_en_o | output | 1 | ROM word access cycle in progress |
| rom_addr_o | output | 23 | ROM word address |
| rom_data_i | input | 16 | ROM word, valid while `rom_en_o` is high |

## Verification
A stale or wrong buffer tag shows up one edge later, as a fast ready carrying the wrong byte or as a hit where the ROM should have been read. A phase counter that drifts or sticks moves the slow ready away from its position two edges after a slot. This is caught on the first slow access. A priority or busy-flag error changes the fast latency from 2 to 1 or 3, or causes a ready with no matching request. The bench checks the latency of every access as well as its data.

// File: rtl/wrom_arb_pkg.sv
package wrom_arb_pkg;
  typedef enum logic {SRC_FAST = 1'b0, SRC_SLOW = 1'b1} src_e;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned FAST_IX   = 0;
  localparam int unsigned SLOW_IX   = 1;
endpackage

// File: rtl/wrom_slot_timer.sv
module wrom_slot_timer #(
  parameter int unsigned PERIOD = 4,
  parameter int unsigned PH_W   = $clog2(PERIOD)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            slot_o,
  output logic [PH_W-1:0] phase_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign slot_o  = (phase_q == '0);
  assign phase_o = phase_q;
endmodule

// File: rtl/wrom_word_buffer.sv
module wrom_word_buffer #(
  parameter int unsigned TAG_W  = 23,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [WORD_W-1:0] fill_word_i,
  input  logic              drop_i,
  input  logic [TAG_W-1:0]  drop_tag_i,
  input  logic [TAG_W-1:0]  probe_tag_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] word_o
);
  logic              valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [WORD_W-1:0] word_q;

  // a fill at the same edge as a foreign-word drop keeps the fresh word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      word_q  <= '0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      tag_q   <= fill_tag_i;
      word_q  <= fill_word_i;
    end else if (drop_i && (drop_tag_i != tag_q)) begin
      valid_q <= 1'b0;
    end
  end

  assign hit_o  = valid_q && (tag_q == probe_tag_i);
  assign word_o = word_q;
endmodule

// File: rtl/wrom_grant_engine.sv
module wrom_grant_engine
  import wrom_arb_pkg::*;
#(
  parameter int unsigned TAG_W  = 23,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              slot_i,
  input  logic                              fast_req_i,
  input  logic                              fast_sel_i,
  input  logic                              fast_lane_i,
  input  logic [TAG_W-1:0]                  fast_tag_i,
  input  logic                              slow_req_i,
  input  logic                              slow_sel_i,
  input  logic                              slow_lane_i,
  input  logic [TAG_W-1:0]                  slow_tag_i,
  input  logic                              buf_hit_i,
  input  logic [WORD_W-1:0]                 buf_word_i,
  input  logic [WORD_W-1:0]                 rom_data_i,
  output logic                              rom_en_o,
  output logic [TAG_W-1:0]                  rom_addr_o,
  output logic                              fill_o,
  output logic                              drop_o,
  output logic [NUM_PORTS-1:0]              done_o,
  output logic [NUM_PORTS-1:0][BYTE_W-1:0]  byte_o
);
  logic             busy_q, fast_wait_q, lane_q;
  src_e             owner_q;
  logic [TAG_W-1:0] waddr_q;

  logic slow_go, fast_want, fast_hit, fast_go;
  logic [BYTE_W-1:0] rom_byte, buf_hi;

  assign slow_go   = slot_i && slow_req_i && slow_sel_i;
  assign fast_want = fast_req_i && fast_sel_i && !fast_wait_q;
  assign fast_hit  = fast_want && fast_lane_i && buf_hit_i;
  assign fast_go   = fast_want && !fast_hit && !slow_go;  // slow wins the slot

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      fast_wait_q <= 1'b0;
      owner_q     <= SRC_FAST;
      lane_q      <= 1'b0;
      waddr_q     <= '0;
    end else begin
      busy_q      <= slow_go || fast_go;
      fast_wait_q <= fast_go;
      if (slow_go) begin
        owner_q <= SRC_SLOW;
        waddr_q <= slow_tag_i;
        lane_q  <= slow_lane_i;
      end else if (fast_go) begin
        owner_q <= SRC_FAST;
        waddr_q <= fast_tag_i;
        lane_q  <= fast_lane_i;
      end
    end
  end

  assign rom_byte = lane_q ? rom_data_i[WORD_W-1:BYTE_W] : rom_data_i[BYTE_W-1:0];
  assign buf_hi   = buf_word_i[WORD_W-1:BYTE_W];

  assign rom_en_o   = busy_q;
  assign rom_addr_o = waddr_q;
  assign fill_o     = busy_q && (owner_q == SRC_FAST);
  assign drop_o     = slow_go;

  always_comb begin
    done_o          = '0;
    byte_o          = '0;
    done_o[FAST_IX] = fill_o || fast_hit;
    byte_o[FAST_IX] = fast_hit ? buf_hi : rom_byte;
    done_o[SLOW_IX] = busy_q && (owner_q == SRC_SLOW);
    byte_o[SLOW_IX] = rom_byte;
  end
endmodule

// File: rtl/wrom_port_return.sv
module wrom_port_return #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              ready_o,
  output logic [BYTE_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      ready_o <= done_i;
      if (done_i) rdata_o <= byte_i;
    end
  end
endmodule

// File: rtl/wide_rom_arbiter.sv
module wide_rom_arbiter
  import wrom_arb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SLOT_PERIOD = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fast_req_i,
  input  logic [ADDR_W-1:0]   fast_addr_i,
  input  logic                fast_sel_i,
  output logic                fast_ready_o,
  output logic [BYTE_W-1:0]   fast_rdata_o,
  input  logic                slow_req_i,
  input  logic [ADDR_W-1:0]   slow_addr_i,
  input  logic                slow_sel_i,
  output logic                slow_ready_o,
  output logic [BYTE_W-1:0]   slow_rdata_o,
  output logic                rom_en_o,
  output logic [ADDR_W-2:0]   rom_addr_o,
  input  logic [2*BYTE_W-1:0] rom_data_i
);
  localparam int unsigned TAG_W  = ADDR_W - 1;
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned PH_W   = $clog2(SLOT_PERIOD);

  logic              slot;
  logic [PH_W-1:0]   slot_phase;
  logic              buf_hit, buf_fill, buf_drop;
  logic [WORD_W-1:0] buf_word;
  logic [NUM_PORTS-1:0]             done;
  logic [NUM_PORTS-1:0][BYTE_W-1:0] lane_byte;
  logic [NUM_PORTS-1:0]             ready;
  logic [NUM_PORTS-1:0][BYTE_W-1:0] rdata;

  wrom_slot_timer #(.PERIOD(SLOT_PERIOD), .PH_W(PH_W)) u_slot (
    .clk_i, .rst_ni, .slot_o(slot), .phase_o(slot_phase)
  );

  wrom_word_buffer #(.TAG_W(TAG_W), .WORD_W(WORD_W)) u_buf (
    .clk_i, .rst_ni,
    .fill_i(buf_fill), .fill_tag_i(rom_addr_o), .fill_word_i(rom_data_i),
    .drop_i(buf_drop), .drop_tag_i(slow_addr_i[ADDR_W-1:1]),
    .probe_tag_i(fast_addr_i[ADDR_W-1:1]),
    .hit_o(buf_hit), .word_o(buf_word)
  );

  wrom_grant_engine #(.TAG_W(TAG_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_eng (
    .clk_i, .rst_ni, .slot_i(slot),
    .fast_req_i, .fast_sel_i, .fast_lane_i(fast_addr_i[0]),
    .fast_tag_i(fast_addr_i[ADDR_W-1:1]),
    .slow_req_i, .slow_sel_i, .slow_lane_i(slow_addr_i[0]),
    .slow_tag_i(slow_addr_i[ADDR_W-1:1]),
    .buf_hit_i(buf_hit), .buf_word_i(buf_word), .rom_data_i,
    .rom_en_o, .rom_addr_o, .fill_o(buf_fill), .drop_o(buf_drop),
    .done_o(done), .byte_o(lane_byte)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ret
    wrom_port_return #(.BYTE_W(BYTE_W)) u_ret (
      .clk_i, .rst_ni, .done_i(done[p]), .byte_i(lane_byte[p]),
      .ready_o(ready[p]), .rdata_o(rdata[p])
    );
  end

  assign fast_ready_o = ready[FAST_IX];
  assign fast_rdata_o = rdata[FAST_IX];
  assign slow_ready_o = ready[SLOW_IX];
  assign slow_rdata_o = rdata[SLOW_IX];
endmodule

// File: rtl/wrom_arb_checker.sv
module wrom_arb_checker #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned PH_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PH_W-1:0]   phase_i,
  input logic              fast_req_i,
  input logic              fast_sel_i,
  input logic              fast_lane_i,
  input logic              fast_ready_i,
  input logic              slow_req_i,
  input logic              slow_sel_i,
  input logic [ADDR_W-1:0] slow_addr_i,
  input logic              slow_ready_i,
  input logic              rom_en_i,
  input logic [ADDR_W-2:0] rom_addr_i
);
  logic slow_take;
  assign slow_take = (phase_i == '0) && slow_req_i && slow_sel_i;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!fast_ready_i && !slow_ready_i && !rom_en_i);
    end
  end

  assert_slow_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_take |=> rom_en_i && (rom_addr_i == $past(slow_addr_i[ADDR_W-1:1])));

  assert_slow_answer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_take |=> ##1 slow_ready_i);

  assert_slow_from_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_ready_i |-> $past(slow_take, 2));

  assert_hit_is_odd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_ready_i && !$past(rom_en_i)) |-> $past(fast_lane_i));

  assert_fast_needs_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_ready_i |-> $past(fast_req_i && fast_sel_i));
endmodule

bind wide_rom_arbiter wrom_arb_checker #(.ADDR_W(ADDR_W), .PH_W(PH_W)) u_chk (
  .clk_i, .rst_ni, .phase_i(slot_phase),
  .fast_req_i, .fast_sel_i, .fast_lane_i(fast_addr_i[0]), .fast_ready_i(fast_ready_o),
  .slow_req_i, .slow_sel_i, .slow_addr_i, .slow_ready_i(slow_ready_o),
  .rom_en_i(rom_en_o), .rom_addr_i(rom_addr_o)
);

// File: tb/test_wide_rom_arbiter.sv
module test_wide_rom_arbiter;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        fast_req, fast_sel, slow_req, slow_sel;
  logic [23:0] fast_addr, slow_addr;
  logic        fast_ready, slow_ready, rom_en;
  logic [7:0]  fast_rdata, slow_rdata;
  logic [22:0] rom_addr;
  logic [15:0] rom_data;

  int checks = 0, failures = 0, edge_cnt = 0, rom_cycles = 0;
  bit finished = 0;
  logic [7:0] fast_exp_q[$], slow_exp_q[$];
  string      fast_tag_q[$], slow_tag_q[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  assign rom_data = {rom_byte({rom_addr, 1'b1}), rom_byte({rom_addr, 1'b0})};

  wide_rom_arbiter i_wide_rom_arbiter (
    .clk_i(clk), .rst_ni,
    .fast_req_i(fast_req), .fast_addr_i(fast_addr), .fast_sel_i(fast_sel),
    .fast_ready_o(fast_ready), .fast_rdata_o(fast_rdata),
    .slow_req_i(slow_req), .slow_addr_i(slow_addr), .slow_sel_i(slow_sel),
    .slow_ready_o(slow_ready), .slow_rdata_o(slow_rdata),
    .rom_en_o(rom_en), .rom_addr_o(rom_addr), .rom_data_i(rom_data)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_ni) begin
    edge_cnt++;
    if (rom_en) rom_cycles++;
  end

  // monitor: pops expected bytes as ready pulses arrive
  always @(negedge clk) if (rst_ni) begin
    if (fast_ready) begin
      if (fast_exp_q.size() == 0) chk(0, "R7", "spurious fast ready", 1, 0);
      else begin
        automatic logic [7:0] e = fast_exp_q.pop_front();
        automatic string t = fast_tag_q.pop_front();
        chk(fast_rdata == e, t, "fast byte", fast_rdata, e);
      end
    end
    if (slow_ready) begin
      if (slow_exp_q.size() == 0) chk(0, "R7", "spurious slow ready", 1, 0);
      else begin
        automatic logic [7:0] e = slow_exp_q.pop_front();
        automatic string t = slow_tag_q.pop_front();
        chk(slow_rdata == e, t, "slow byte", slow_rdata, e);
      end
    end
  end

  task automatic fast_access(input logic [23:0] a, input int exp_lat, input string rq);
    int lat = 0;
    fast_exp_q.push_back(rom_byte(a));
    fast_tag_q.push_back(rq);
    fast_req = 1'b1; fast_sel = 1'b1; fast_addr = a;
    do begin @(negedge clk); lat++; end while (!fast_ready && lat < 20);
    chk(lat == exp_lat, rq, "fast latency", lat, exp_lat);
  endtask

  task automatic fast_idle();
    fast_req = 1'b0;
  endtask

  task automatic slow_access(input logic [23:0] a, input int exp_lat, input string rq);
    int lat = 0;
    slow_exp_q.push_back(rom_byte(a));
    slow_tag_q.push_back(rq);
    slow_req = 1'b1; slow_sel = 1'b1; slow_addr = a;
    do begin @(negedge clk); lat++; end while (!slow_ready && lat < 20);
    chk(lat == exp_lat, rq, "slow latency", lat, exp_lat);
    slow_req = 1'b0;
  endtask

  // call at a negedge; returns at the negedge before an edge with index%4 == m
  task automatic wait_mod(input int m);
    while ((edge_cnt % 4) != m) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int c0, t;
    rst_ni = 1'b0;
    fast_req = 0; fast_sel = 0; fast_addr = '0;
    slow_req = 0; slow_sel = 0; slow_addr = '0;
    repeat (3) @(negedge clk);
    chk(!fast_ready && !slow_ready, "R1", "ready low in reset", fast_ready | slow_ready, 0);
    chk(!rom_en, "R1", "rom_en low in reset", rom_en, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: empty buffer, odd read misses
    c0 = rom_cycles;
    fast_access(24'h000101, 2, "R1");
    fast_idle();
    chk(rom_cycles == c0 + 1, "R1", "rom cycle after reset", rom_cycles - c0, 1);

    // R2: even miss
    c0 = rom_cycles;
    fast_access(24'h001000, 2, "R2");
    fast_idle();
    chk(rom_cycles == c0 + 1, "R2", "one rom cycle", rom_cycles - c0, 1);

    // R3 / R11: alternating even/odd, 4 bytes in 6 cycles
    wait_mod(1);
    c0 = rom_cycles; t = edge_cnt;
    fast_access(24'h002000, 2, "R11");
    fast_access(24'h002001, 1, "R3");
    fast_access(24'h002002, 2, "R11");
    fast_access(24'h002003, 1, "R3");
    fast_idle();
    chk(edge_cnt - t == 6, "R11", "4 bytes cycles", edge_cnt - t, 6);
    chk(rom_cycles - c0 == 2, "R3", "hits skip rom", rom_cycles - c0, 2);

    // R4: even byte of buffered word refetches
    c0 = rom_cycles;
    fast_access(24'h002002, 2, "R4");
    fast_idle();
    chk(rom_cycles - c0 == 1, "R4", "even refetch", rom_cycles - c0, 1);

    // R11: back-to-back misses
    wait_mod(1);
    t = edge_cnt;
    fast_access(24'h003000, 2, "R11");
    fast_access(24'h003010, 2, "R11");
    fast_access(24'h003021, 2, "R11");
    fast_idle();
    chk(edge_cnt - t == 6, "R11", "3 misses cycles", edge_cnt - t, 6);

    // R5: slow at slot, and just after a slot
    wait_mod(0);
    slow_access(24'h004005, 2, "R5");
    wait_mod(1);
    slow_access(24'h004106, 5, "R5");

    // R6: contention at the slot
    wait_mod(0);
    c0 = rom_cycles;
    fork
      slow_access(24'h005000, 2, "R6");
      begin fast_access(24'h006000, 3, "R6"); fast_idle(); end
    join
    chk(rom_cycles - c0 == 2, "R6", "two rom cycles", rom_cycles - c0, 2);

    // R7: deselected fast request ignored
    c0 = rom_cycles;
    fast_req = 1; fast_sel = 0; fast_addr = 24'h00F000;
    repeat (6) @(negedge clk);
    fast_req = 0;
    chk(rom_cycles == c0, "R7", "no rom for deselected", rom_cycles - c0, 0);
    // R7: deselected slow does not delay fast
    wait_mod(0);
    fork
      begin
        slow_req = 1; slow_sel = 0; slow_addr = 24'h00E000;
        repeat (4) @(negedge clk);
        slow_req = 0;
      end
      begin fast_access(24'h007000, 2, "R7"); fast_idle(); end
    join

    // R8 then R9: hit served alongside slow grant; then buffer emptied
    fast_access(24'h008000, 2, "R8");
    fast_idle();
    wait_mod(0);
    fork
      slow_access(24'h009000, 2, "R8");
      begin fast_access(24'h008001, 1, "R8"); fast_idle(); end
    join
    fast_access(24'h008001, 2, "R9");
    fast_idle();

    // R9: slow fetch of same word keeps buffer
    fast_access(24'h00A000, 2, "R9");
    fast_idle();
    wait_mod(0);
    slow_access(24'h00A000, 2, "R9");
    fast_access(24'h00A001, 1, "R9");
    fast_idle();

    // R10 / R9: fast miss just before slot, fill wins over drop
    wait_mod(3);
    fork
      begin fast_access(24'h00B000, 2, "R10"); fast_idle(); end
      begin @(negedge clk); slow_access(24'h00C000, 2, "R10"); end
    join
    fast_access(24'h00B001, 1, "R9");
    fast_idle();

    repeat (4) @(negedge clk);
    chk(fast_exp_q.size() == 0, "R2", "fast scoreboard drained", fast_exp_q.size(), 0);
    chk(slow_exp_q.size() == 0, "R5", "slow scoreboard drained", slow_exp_q.size(), 0);
    finish_run();
  end
endmodule